// File: doc/BRIEF.md
# Triggered Serial Hit Readout Framer

The block waits for a trigger. When one is accepted it takes a snapshot of 64 per-channel hit bits and clears any channel that the dead-channel mask marks. It then builds a self-describing frame and sends it on one serial data line. The frame holds a sync pattern, two status bits, a rolling 5-bit trigger count, the chip identifier that is strapped on the board, the 64 masked hit bits and a closing zero byte.

The readout clock that goes with the data exists only while a frame is being sent. Between events both the clock and the data line stay low. Each frame bit takes two system clock cycles. The data changes while the readout clock is low and holds steady while it is high, so a receiver samples on the rising edge. At a 100 MHz system clock the readout clock runs at 50 MHz, and a 96-bit frame takes 1.92 µs.

A trigger that arrives while a frame is being sent does not restart or change that frame. It is counted only as an overflow indication in the next frame.

Top module: `hf_readout`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy_o`, `rd_clk_o` and `sdo_o` are all 0.
- R2: A trigger accepted while idle makes `busy_o` rise on the next clock edge. `busy_o` then stays high for exactly 192 cycles, in which `rd_clk_o` pulses high 96 times. Each pulse lasts one cycle and is preceded by one low cycle.
- R3: The first 8 frame bits are the sync pattern 8'b1010_1100, most significant bit first.
- R4: Frame bit 8 (0-based from the first bit sent) is 1 exactly when at least one trigger was dropped since the previous accepted trigger. Frame bit 9 is always 0.
- R5: Frame bits 10..14 carry the trigger count, MSB first. It is 0 in the first frame after reset, rises by one per accepted trigger, and wraps from 31 to 0.
- R6: Frame bits 15..23 carry `chip_id_i`, MSB first, as sampled on the trigger cycle.
- R7: Frame bits 24..87 carry channels 63 down to 0. Each bit is `hits_i[ch]` AND NOT `mask_i[ch]`.
- R8: Hit, mask and ID inputs are sampled only on the accepting cycle. Later changes do not alter the frame in progress.
- R9: Frame bits 88..95 are all 0.
- R10: A trigger seen while `busy_o` is high is dropped, including one on the final busy cycle. The frame in progress keeps its length and content.
- R11: `sdo_o` changes only in a cycle where `rd_clk_o` is low, and it is stable in every cycle where `rd_clk_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the readout bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger request, sampled each clock |
| hits_i | input | 64 | Latched per-channel hit bits |
| mask_i | input | 64 | Dead-channel mask, 1 forces the channel to 0 |
| chip_id_i | input | 9 | Hardware-strapped chip identifier |
| sdo_o | output | 1 | Serial frame data, MSB first |
| rd_clk_o | output | 1 | Readout clock, toggles only during a frame |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The checker watches the port-level framing rules on every cycle: a quiet line when idle, no readout clock outside a frame, data stable while the clock is high, a fixed frame length, the sync pattern at the head of the frame and the zero tail. Field contents cannot be judged from a single cycle. These are the trigger count and its wrap, the overflow bit and which trigger set it, the mask, the channel order, the chip ID and the snapshot taken at the trigger. Only the bench scenarios show them, by rebuilding each frame from the stimulus and comparing it with the deserialized bits.

// File: rtl/hf_pkg.sv
package hf_pkg;
   localparam int          SYNC_W   = 8;
   localparam logic [7:0]  SYNC_PAT = 8'b1010_1100;
   localparam int          STAT_W   = 2;
   localparam int          TAIL_W   = 8;
endpackage

// File: rtl/hf_seq.sv
// Frame sequencer: trigger acceptance, bit/phase timing, trigger count, overflow flag.
module hf_seq #(
   parameter int FRAME_W = 96,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   output logic             load_o,
   output logic             shift_o,
   output logic             busy_o,
   output logic             phase_o,
   output logic             ovf_o,
   output logic [CNT_W-1:0] tcnt_o
);
   localparam int BIT_W = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   logic [BIT_W-1:0] bit_q;
   logic             last_w;

   assign last_w  = (bit_q == LAST_BIT);
   assign load_o  = trig_i & ~busy_o;
   assign shift_o = busy_o & phase_o & ~last_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         phase_o <= 1'b0;
         bit_q   <= '0;
      end else if (load_o) begin
         busy_o  <= 1'b1;
         phase_o <= 1'b0;
         bit_q   <= '0;
      end else if (busy_o) begin
         phase_o <= ~phase_o;
         if (phase_o) begin
            if (last_w) busy_o <= 1'b0;
            else        bit_q  <= bit_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o  <= 1'b0;
         tcnt_o <= '0;
      end else if (load_o) begin
         ovf_o  <= 1'b0;
         tcnt_o <= tcnt_o + 1'b1;
      end else if (trig_i && busy_o) begin
         ovf_o  <= 1'b1;
      end
   end
endmodule

// File: rtl/hf_frame_build.sv
// Assembles the frame word from the live inputs and the sequencer state.
module hf_frame_build #(
   parameter int NCH     = 64,
   parameter int CNT_W   = 5,
   parameter int ID_W    = 9,
   parameter int FRAME_W = 96
) (
   input  logic [NCH-1:0]     hits_i,
   input  logic [NCH-1:0]     mask_i,
   input  logic [ID_W-1:0]    chip_id_i,
   input  logic               ovf_i,
   input  logic [CNT_W-1:0]   tcnt_i,
   output logic [FRAME_W-1:0] frame_o
);
   import hf_pkg::*;

   logic [NCH-1:0] data_w;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      assign data_w[ch] = hits_i[ch] & ~mask_i[ch];
   end

   assign frame_o = {SYNC_PAT, ovf_i, 1'b0, tcnt_i, chip_id_i, data_w, {TAIL_W{1'b0}}};
endmodule

// File: rtl/hf_shifter.sv
// Parallel-load, MSB-first shift register.
module hf_shifter #(
   parameter int FRAME_W = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               shift_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               msb_o
);
   logic [FRAME_W-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q <= '0;
      else if (load_i)  sreg_q <= frame_i;
      else if (shift_i) sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
   end

   assign msb_o = sreg_q[FRAME_W-1];
endmodule

// File: rtl/hf_readout.sv
module hf_readout #(
   parameter int NCH   = 64,
   parameter int CNT_W = 5,
   parameter int ID_W  = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_i,
   input  logic [NCH-1:0]  hits_i,
   input  logic [NCH-1:0]  mask_i,
   input  logic [ID_W-1:0] chip_id_i,
   output logic            sdo_o,
   output logic            rd_clk_o,
   output logic            busy_o
);
   import hf_pkg::*;

   localparam int FRAME_W = SYNC_W + STAT_W + CNT_W + ID_W + NCH + TAIL_W;

   if (NCH < 1)       $error("hf_readout: NCH must be at least 1");
   if (CNT_W < 1)     $error("hf_readout: CNT_W must be at least 1");
   if (ID_W < 1)      $error("hf_readout: ID_W must be at least 1");

   logic               load_w, shift_w, phase_w, ovf_w, msb_w, busy_w;
   logic [CNT_W-1:0]   tcnt_w;
   logic [FRAME_W-1:0] frame_w;

   hf_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
      .load_o(load_w), .shift_o(shift_w), .busy_o(busy_w),
      .phase_o(phase_w), .ovf_o(ovf_w), .tcnt_o(tcnt_w)
   );

   hf_frame_build #(.NCH(NCH), .CNT_W(CNT_W), .ID_W(ID_W), .FRAME_W(FRAME_W)) build_i (
      .hits_i(hits_i), .mask_i(mask_i), .chip_id_i(chip_id_i),
      .ovf_i(ovf_w), .tcnt_i(tcnt_w), .frame_o(frame_w)
   );

   hf_shifter #(.FRAME_W(FRAME_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .shift_i(shift_w),
      .frame_i(frame_w), .msb_o(msb_w)
   );

   assign busy_o   = busy_w;
   assign sdo_o    = busy_w & msb_w;
   assign rd_clk_o = busy_w & phase_w;
endmodule

// File: rtl/hf_readout_chk.sv
module hf_readout_chk #(
   parameter int FRAME_W = 96
) (
   input logic clk,
   input logic rst_n,
   input logic trig_i,
   input logic sdo_o,
   input logic rd_clk_o,
   input logic busy_o
);
   import hf_pkg::*;

   localparam int CYC   = 2 * FRAME_W;
   localparam int CNT_W = $clog2(CYC) + 1;

   logic [CNT_W-1:0] cyc_q;
   logic             hdr_bit;
   logic             in_hdr;
   logic             in_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cyc_q <= '0;
      else if (busy_o) cyc_q <= cyc_q + 1'b1;
      else             cyc_q <= '0;
   end

   always_comb begin
      in_hdr  = (int'(cyc_q) < 2 * SYNC_W);
      in_tail = (int'(cyc_q) >= CYC - 2 * TAIL_W);
      hdr_bit = 1'b0;
      if (in_hdr) hdr_bit = SYNC_PAT[SYNC_W - 1 - (int'(cyc_q) / 2)];
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sdo_o && !rd_clk_o));

   a_r2_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (int'($past(cyc_q)) == CYC - 1));

   a_r10_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && int'(cyc_q) < CYC - 1) |=> busy_o);

   a_r11_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clk_o |-> $stable(sdo_o));

   a_r3_sync_head: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && in_hdr) |-> (sdo_o == hdr_bit));

   a_r9_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && in_tail) |-> !sdo_o);
endmodule

bind hf_readout hf_readout_chk #(.FRAME_W(FRAME_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
   .sdo_o(sdo_o), .rd_clk_o(rd_clk_o), .busy_o(busy_o)
);

// File: tb/hf_readout_tb_top.sv
module hf_readout_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_i = 1'b0;
   logic [63:0] hits_i = '0;
   logic [63:0] mask_i = '0;
   logic [8:0]  chip_id_i = '0;
   logic        sdo_o, rd_clk_o, busy_o;

   int errors = 0;
   int checks = 0;
   int exp_cnt = 0;
   logic [95:0] got;
   int busy_cyc, clk_pulses;

   always #5 clk = ~clk;

   hf_readout dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .hits_i(hits_i),
      .mask_i(mask_i), .chip_id_i(chip_id_i),
      .sdo_o(sdo_o), .rd_clk_o(rd_clk_o), .busy_o(busy_o)
   );

   typedef struct packed {
      logic [63:0] hits;
      logic [63:0] mask;
      logic [8:0]  id;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{hits: 64'hFFFF_FFFF_FFFF_FFFF, mask: 64'h0,                   id: 9'h1A5},
      '{hits: 64'h8000_0000_0000_0001, mask: 64'h0,                   id: 9'h000},
      '{hits: 64'hDEAD_BEEF_0123_4567, mask: 64'hFF00_0000_0000_00F0, id: 9'h1FF},
      '{hits: 64'hFFFF_FFFF_FFFF_FFFF, mask: 64'hAAAA_AAAA_AAAA_AAAA, id: 9'h0C3}
   };

   task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Issues a trigger, deserializes the frame. inj_at >= 0 pulses trig and
   // replaces the hit/mask/id inputs at that busy cycle.
   task automatic run_frame(input logic [63:0] h, input logic [63:0] m, input logic [8:0] id,
                            input int inj_at, input logic [63:0] h2);
      @(negedge clk);
      hits_i = h; mask_i = m; chip_id_i = id; trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      got = '0; busy_cyc = 0; clk_pulses = 0;
      while (busy_o && busy_cyc < 400) begin
         if (rd_clk_o) begin
            got = {got[94:0], sdo_o};
            clk_pulses++;
         end
         trig_i = (busy_cyc == inj_at);
         if (busy_cyc == inj_at) begin
            hits_i = h2; mask_i = ~m; chip_id_i = ~id;
         end
         busy_cyc++;
         @(negedge clk);
      end
      trig_i = 1'b0;
   endtask

   task automatic check_frame(input logic [63:0] h, input logic [63:0] m, input logic [8:0] id,
                              input bit ovf);
      logic [95:0] exp;
      exp = {8'b1010_1100, ovf, 1'b0, 5'(exp_cnt), id, h & ~m, 8'h00};
      chk(busy_cyc == 192, "R2 busy length", 96'(busy_cyc), 96'd192);
      chk(clk_pulses == 96, "R2 clock pulses", 96'(clk_pulses), 96'd96);
      chk(got[95:88] == 8'hAC, "R3 sync", 96'(got[95:88]), 96'hAC);
      chk(got[87] == ovf && got[86] == 1'b0, "R4 status", 96'(got[87:86]), 96'({ovf, 1'b0}));
      chk(got[85:81] == 5'(exp_cnt), "R5 trigger count", 96'(got[85:81]), 96'(5'(exp_cnt)));
      chk(got[80:72] == id, "R6 chip id", 96'(got[80:72]), 96'(id));
      chk(got[71:8] == (h & ~m), "R7 data", 96'(got[71:8]), 96'(h & ~m));
      chk(got[7:0] == 8'h00, "R9 tail", 96'(got[7:0]), 96'h0);
      exp_cnt = (exp_cnt + 1) % 32;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !rd_clk_o && !sdo_o, "R1 reset", 96'({busy_o, rd_clk_o, sdo_o}), 96'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && !rd_clk_o && !sdo_o, "R1 idle", 96'({busy_o, rd_clk_o, sdo_o}), 96'h0);

      // Table-driven frames (R2..R7, R9)
      foreach (VECS[i]) begin
         run_frame(VECS[i].hits, VECS[i].mask, VECS[i].id, -1, '0);
         check_frame(VECS[i].hits, VECS[i].mask, VECS[i].id, 1'b0);
         chk(!busy_o && !rd_clk_o && !sdo_o, "R1 between frames", 96'({busy_o, rd_clk_o, sdo_o}), 96'h0);
      end

      // R8 + R10: trigger and new inputs mid-frame do not disturb it
      run_frame(64'h0123_4567_89AB_CDEF, 64'h0, 9'h055, 50, 64'hFFFF_0000_FFFF_0000);
      check_frame(64'h0123_4567_89AB_CDEF, 64'h0, 9'h055, 1'b0);
      // R4: next frame reports the dropped trigger, then it clears
      run_frame(64'h1, 64'h0, 9'h101, -1, '0);
      check_frame(64'h1, 64'h0, 9'h101, 1'b1);
      run_frame(64'h2, 64'h0, 9'h102, -1, '0);
      check_frame(64'h2, 64'h0, 9'h102, 1'b0);

      // R10: trigger on the final busy cycle is dropped
      run_frame(64'h3, 64'h0, 9'h003, 191, 64'h0);
      check_frame(64'h3, 64'h0, 9'h003, 1'b0);
      @(negedge clk);
      chk(!busy_o, "R10 last-cycle trigger dropped", 96'(busy_o), 96'h0);
      run_frame(64'h4, 64'h0, 9'h004, -1, '0);
      check_frame(64'h4, 64'h0, 9'h004, 1'b1);

      // R5: run past the wrap from 31 to 0
      for (int k = 0; k < 30; k++) begin
         run_frame(64'(k), 64'h0, 9'(k), -1, '0);
         check_frame(64'(k), 64'h0, 9'(k), 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule